// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Access Rights

This block caches virtual-to-physical page mappings for a 32-bit virtual address space with 64 KB pages. A request supplies a virtual address, a process identifier and an access kind (load, store or fetch). Every stored entry is compared against the request at the same time. One cycle later the block answers with exactly one of three outcomes: a hit that carries the 28-bit physical address, a miss that tells the surrounding logic to walk the page table and refill, or a protection fault when the entry exists but forbids that kind of access.

Each entry's tag holds the process identifier next to the virtual page number. This lets translations from several processes live side by side across context switches. Software-side logic writes entries through a fill port. It can invalidate all entries at once, or only the entries that belong to one process. A fill reuses an entry that already holds the same page and process. Otherwise it takes the lowest free slot, and when no slot is free it takes the slot named by a rotating victim pointer.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, rsp_pa equals the stored 12-bit physical page number in bits [27:16] followed by request address bits [15:0] unchanged; request address bits [31:16] form the virtual page number.
- R2: A request hits when any valid entry holds its virtual page number and process identifier, whichever of the ENTRIES slots holds it.
- R3: A request that matches no valid entry reports rsp_miss; on a miss or a fault rsp_pa is zero.
- R4: The process identifier is part of the match: the same page number under another identifier misses.
- R5: req_acc encodes load=0, store=1, fetch=2 (3 is reserved and always faults); fill_perm bit 0 grants read, bit 1 write, bit 2 execute. A matching entry that lacks the right for the access kind reports rsp_fault and not rsp_hit.
- R6: rsp_valid is req_valid delayed one cycle, and with it exactly one of rsp_hit, rsp_miss, rsp_fault is high; all four are low otherwise.
- R7: A fill with no duplicate goes into the lowest-numbered invalid entry when one exists, leaving the victim pointer unchanged.
- R8: When every entry is valid, a new fill replaces the entry at the victim pointer, which then advances by one and wraps from ENTRIES-1 to 0.
- R9: A fill whose page number and identifier match a valid entry rewrites that entry's physical page and rights in place; no other entry and not the victim pointer changes.
- R10: flush_all invalidates every entry in one cycle and overrides a fill or per-process flush given in the same cycle.
- R11: flush_pid_en invalidates exactly the entries whose identifier equals flush_pid.
- R12: A lookup sees the table as it was before any fill or flush applied in the same cycle; the change is visible to a lookup one cycle later.
- R13: After reset no entry is valid, the victim pointer is 0 and all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address to translate |
| req_pid | input | 8 | Process identifier of the request |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation found and access permitted |
| rsp_miss | output | 1 | No matching entry, refill needed |
| rsp_fault | output | 1 | Matching entry forbids this access kind |
| rsp_pa | output | 28 | Physical address on a hit, zero otherwise |
| fill_en | input | 1 | Write an entry |
| fill_vpn | input | 16 | Virtual page number of the fill |
| fill_pid | input | 8 | Process identifier of the fill |
| fill_ppn | input | 12 | Physical page number of the fill |
| fill_perm | input | 3 | Rights of the fill: bit0 read, bit1 write, bit2 execute |
| flush_all | input | 1 | Invalidate every entry |
| flush_pid_en | input | 1 | Invalidate entries of one process |
| flush_pid | input | 8 | Process identifier to invalidate |

## Verification
Every response output is registered, so a request driven in one cycle is answered in the next: the bench drives on the falling edge and reads the outcome at the falling edge that follows the next rising edge. A fill or flush changes the table at the same rising edge, so the bench starts the next lookup no earlier than the following cycle. Only the same-cycle case of R12 is driven on purpose, and there the bench expects the old table. After every table change the bench compares all keys it has ever written against its own table model, using all three access kinds. Any eviction order, overwrite or flush that differs from the requirements therefore shows up as a wrong outcome.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;

    function automatic logic perm_allows(input logic [2:0] perm, input acc_e acc);
        case (acc)
            ACC_LOAD:  return perm[PERM_RD];
            ACC_STORE: return perm[PERM_WR];
            ACC_FETCH: return perm[PERM_EX];
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
    parameter int N     = 16,
    parameter int VPN_W = 16,
    parameter int PID_W = 8
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][VPN_W-1:0] tag_vpn,
    input  logic [N-1:0][PID_W-1:0] tag_pid,
    input  logic [VPN_W-1:0]        key_vpn,
    input  logic [PID_W-1:0]        key_pid,
    output logic [N-1:0]            match
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = vld[i] && (tag_vpn[i] == key_vpn) && (tag_pid[i] == key_pid);
    end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter  int ENTRIES = 16,
    parameter  int VPN_W   = 16,
    parameter  int PPN_W   = 12,
    parameter  int OFS_W   = 16,
    parameter  int PID_W   = 8,
    localparam int VA_W    = VPN_W + OFS_W,
    localparam int PA_W    = PPN_W + OFS_W,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic [PID_W-1:0] req_pid,
    input  logic [1:0]       req_acc,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_pa,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [2:0]       fill_perm,
    input  logic             flush_all,
    input  logic             flush_pid_en,
    input  logic [PID_W-1:0] flush_pid
);

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PID_W-1:0] pid;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [ENTRIES-1:0][2:0]       perm;
        logic [IDX_W-1:0]              rr;
        logic                          rsp_v;
        logic                          hit;
        logic                          miss;
        logic                          fault;
        logic [PA_W-1:0]               pa;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [ENTRIES-1:0] lk_match, fl_match;
    logic               lk_any, fl_any, free_any;
    logic [IDX_W-1:0]   lk_idx, fl_idx, free_idx, wr_idx;
    logic               acc_ok;

    tlb_tag_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_lookup_cmp (
        .vld     (st_q.vld),
        .tag_vpn (st_q.vpn),
        .tag_pid (st_q.pid),
        .key_vpn (req_va[VA_W-1:OFS_W]),
        .key_pid (req_pid),
        .match   (lk_match)
    );

    tlb_tag_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_fill_cmp (
        .vld     (st_q.vld),
        .tag_vpn (st_q.vpn),
        .tag_pid (st_q.pid),
        .key_vpn (fill_vpn),
        .key_pid (fill_pid),
        .match   (fl_match)
    );

    tlb_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_lookup_enc (
        .req (lk_match),
        .any (lk_any),
        .idx (lk_idx)
    );

    tlb_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_fill_enc (
        .req (fl_match),
        .any (fl_any),
        .idx (fl_idx)
    );

    tlb_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_free_enc (
        .req (~st_q.vld),
        .any (free_any),
        .idx (free_idx)
    );

    always_comb begin
        st_d   = st_q;
        acc_ok = perm_allows(st_q.perm[lk_idx], acc_e'(req_acc));

        // response of this cycle's request, from the table before any update
        st_d.rsp_v = req_valid;
        st_d.hit   = req_valid && lk_any && acc_ok;
        st_d.miss  = req_valid && !lk_any;
        st_d.fault = req_valid && lk_any && !acc_ok;
        st_d.pa    = (req_valid && lk_any && acc_ok)
                   ? {st_q.ppn[lk_idx], req_va[OFS_W-1:0]} : '0;

        // placement: duplicate, then lowest free slot, then rotating victim
        wr_idx = fl_any ? fl_idx : (free_any ? free_idx : st_q.rr);

        if (flush_all) begin
            st_d.vld = '0;
        end else begin
            if (flush_pid_en) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (st_q.pid[i] == flush_pid) st_d.vld[i] = 1'b0;
                end
            end
            if (fill_en) begin
                st_d.vpn[wr_idx]  = fill_vpn;
                st_d.pid[wr_idx]  = fill_pid;
                st_d.ppn[wr_idx]  = fill_ppn;
                st_d.perm[wr_idx] = fill_perm;
                st_d.vld[wr_idx]  = 1'b1;
                if (!fl_any && !free_any) begin
                    st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_hit   = st_q.hit;
    assign rsp_miss  = st_q.miss;
    assign rsp_fault = st_q.fault;
    assign rsp_pa    = st_q.pa;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int VPN_W = 16,
    parameter int OFS_W = 16,
    parameter int PID_W = 8,
    parameter int PA_W  = 28
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [VPN_W+OFS_W-1:0] req_va,
    input logic [PID_W-1:0]       req_pid,
    input logic                   rsp_valid,
    input logic                   rsp_hit,
    input logic                   rsp_miss,
    input logic                   rsp_fault,
    input logic [PA_W-1:0]        rsp_pa,
    input logic                   fill_en,
    input logic [VPN_W-1:0]       fill_vpn,
    input logic [PID_W-1:0]       fill_pid,
    input logic                   flush_all
);
    localparam int VA_W = VPN_W + OFS_W;

    // R6
    req_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R6
    no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R6
    single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

    // R6
    idle_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

    // R1
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || rsp_pa[OFS_W-1:0] == $past(req_va[OFS_W-1:0])));

    // R3
    pa_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss || rsp_fault) |-> rsp_pa == '0);

    // R10
    flushed_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all ##1 req_valid) |=> rsp_miss);

    // R12
    filled_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill_en && !flush_all) ##1
         (req_valid && req_va[VA_W-1:OFS_W] == $past(fill_vpn) && req_pid == $past(fill_pid)))
        |=> !rsp_miss);
endmodule

bind tlb_xlate tlb_xlate_chk #(
    .VPN_W (VPN_W),
    .OFS_W (OFS_W),
    .PID_W (PID_W),
    .PA_W  (PA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_va    (req_va),
    .req_pid   (req_pid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_pa    (rsp_pa),
    .fill_en   (fill_en),
    .fill_vpn  (fill_vpn),
    .fill_pid  (fill_pid),
    .flush_all (flush_all)
);

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
module tlb_xlate_test;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [7:0]  req_pid = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [27:0] rsp_pa;
    logic        fill_en = 1'b0;
    logic [15:0] fill_vpn = '0;
    logic [7:0]  fill_pid = '0;
    logic [11:0] fill_ppn = '0;
    logic [2:0]  fill_perm = '0;
    logic        flush_all = 1'b0;
    logic        flush_pid_en = 1'b0;
    logic [7:0]  flush_pid = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    tlb_xlate uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_va(req_va), .req_pid(req_pid), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .flush_all(flush_all), .flush_pid_en(flush_pid_en), .flush_pid(flush_pid)
    );

    // reference table
    bit          m_vld [N];
    logic [15:0] m_vpn [N];
    logic [7:0]  m_pid [N];
    logic [11:0] m_ppn [N];
    logic [2:0]  m_perm[N];
    int          m_rr = 0;

    // every key ever written or probed
    logic [15:0] k_vpn[64];
    logic [7:0]  k_pid[64];
    int          n_keys = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic add_key(input logic [15:0] v, input logic [7:0] p);
        if (n_keys < 64) begin
            k_vpn[n_keys] = v;
            k_pid[n_keys] = p;
            n_keys++;
        end
    endtask

    // outcome code: 0 miss, 1 hit, 2 fault
    function automatic int ref_lookup(input logic [15:0] v, input logic [7:0] p,
                                      input logic [1:0] acc, output logic [11:0] ppn);
        ppn = '0;
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] && m_vpn[i] == v && m_pid[i] == p) begin
                ppn = m_ppn[i];
                if (acc != 2'd3 && m_perm[i][acc]) return 1;
                return 2;
            end
        end
        return 0;
    endfunction

    function automatic void ref_fill(input logic [15:0] v, input logic [7:0] p,
                                     input logic [11:0] ppn, input logic [2:0] perm);
        int slot = -1;
        for (int i = 0; i < N; i++)
            if (slot < 0 && m_vld[i] && m_vpn[i] == v && m_pid[i] == p) slot = i;
        if (slot < 0)
            for (int i = 0; i < N; i++)
                if (slot < 0 && !m_vld[i]) slot = i;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % N;
        end
        m_vld[slot] = 1'b1; m_vpn[slot] = v; m_pid[slot] = p;
        m_ppn[slot] = ppn;  m_perm[slot] = perm;
    endfunction

    task automatic drive_fill(input logic [15:0] v, input logic [7:0] p,
                              input logic [11:0] ppn, input logic [2:0] perm);
        fill_en = 1'b1; fill_vpn = v; fill_pid = p; fill_ppn = ppn; fill_perm = perm;
    endtask

    task automatic do_fill(input logic [15:0] v, input logic [7:0] p,
                           input logic [11:0] ppn, input logic [2:0] perm);
        @(negedge clk);
        drive_fill(v, p, ppn, perm);
        @(negedge clk);
        fill_en = 1'b0;
        ref_fill(v, p, ppn, perm);
        add_key(v, p);
    endtask

    task automatic check_rsp(input string req, input int exp_code, input logic [11:0] exp_ppn,
                             input logic [15:0] ofs);
        chk(req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk(req, "rsp_hit",   {31'd0, rsp_hit},   {31'd0, exp_code == 1});
        chk(req, "rsp_miss",  {31'd0, rsp_miss},  {31'd0, exp_code == 0});
        chk(req, "rsp_fault", {31'd0, rsp_fault}, {31'd0, exp_code == 2});
        chk(req, "rsp_pa",    {4'd0, rsp_pa},
            (exp_code == 1) ? {4'd0, exp_ppn, ofs} : 32'd0);
    endtask

    task automatic lookup(input string req, input logic [15:0] v, input logic [7:0] p,
                          input logic [1:0] acc, input logic [15:0] ofs);
        logic [11:0] eppn;
        int code;
        code = ref_lookup(v, p, acc, eppn);
        @(negedge clk);
        req_valid = 1'b1; req_va = {v, ofs}; req_pid = p; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(req, code, eppn, ofs);
    endtask

    // every known key, every access kind (R1 R2 R4 R5 and placement checks)
    task automatic sweep(input string req);
        for (int k = 0; k < n_keys; k++) begin
            for (int a = 0; a < 3; a++) begin
                lookup(req, k_vpn[k], k_pid[k], 2'(a), 16'(k * 16'h0973 + a));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: quiet outputs and empty table after reset
        chk("R13", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R13", "rsp_hit",   {31'd0, rsp_hit},   32'd0);
        chk("R13", "rsp_miss",  {31'd0, rsp_miss},  32'd0);
        chk("R13", "rsp_fault", {31'd0, rsp_fault}, 32'd0);
        lookup("R13_R3", 16'h0000, 8'd0, 2'd0, 16'h1234);

        // R7 R2 R1 R5: fill an empty table, every rights pattern present
        for (int i = 0; i < N; i++)
            do_fill(16'h1000 + 16'(i * 16'h0351), 8'(i % 4 + 1), 12'hA00 ^ 12'(i * 7), 3'(i % 8));
        sweep("R2_R1_R5_R7");

        // R5: reserved access code always faults on a present entry
        lookup("R5", 16'h1000, 8'd1, 2'd3, 16'h00FF);

        // R4: same pages under an unused identifier
        for (int i = 0; i < 4; i++) add_key(16'h1000 + 16'(i * 16'h0351), 8'd9);
        sweep("R4");

        // R9: duplicate fill rewrites in place, pointer untouched
        do_fill(16'h1000 + 16'(5 * 16'h0351), 8'd2, 12'h5EE, 3'b111);
        sweep("R9");

        // R8: full table, rotating replacement through a wrap
        for (int i = 0; i < N + 2; i++)
            do_fill(16'hF000 + 16'(i), 8'd3, 12'h100 + 12'(i), 3'b011);
        sweep("R8");

        // R12: lookup and fill of a new key in one cycle sees the old table
        @(negedge clk);
        req_valid = 1'b1; req_va = {16'hBEEF, 16'h0042}; req_pid = 8'd7; req_acc = 2'd0;
        drive_fill(16'hBEEF, 8'd7, 12'h777, 3'b001);
        @(negedge clk);
        req_valid = 1'b0; fill_en = 1'b0;
        check_rsp("R12", 0, 12'h000, 16'h0042);
        ref_fill(16'hBEEF, 8'd7, 12'h777, 3'b001);
        add_key(16'hBEEF, 8'd7);
        lookup("R12", 16'hBEEF, 8'd7, 2'd0, 16'h0042);

        // R11: per-process flush
        @(negedge clk);
        flush_pid_en = 1'b1; flush_pid = 8'd3;
        @(negedge clk);
        flush_pid_en = 1'b0;
        for (int i = 0; i < N; i++) if (m_pid[i] == 8'd3) m_vld[i] = 1'b0;
        sweep("R11");

        // R7: fills land in freed slots, the rotating victim survives
        do_fill(16'h7001, 8'd5, 12'hC01, 3'b101);
        do_fill(16'h7002, 8'd5, 12'hC02, 3'b110);
        sweep("R7");

        // R10: flush_all overrides a fill in the same cycle
        @(negedge clk);
        flush_all = 1'b1;
        drive_fill(16'h6666, 8'd1, 12'h666, 3'b111);
        @(negedge clk);
        flush_all = 1'b0; fill_en = 1'b0;
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        add_key(16'h6666, 8'd1);
        sweep("R10");

        // R7 R13: after a full flush placement restarts at the lowest slot
        do_fill(16'h2222, 8'd4, 12'h222, 3'b111);
        sweep("R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule